// File: doc/BRIEF.md
# Flow-Through Burst SRAM Core

This block is a cycle-level model of a synchronous burst static memory that runs in flow-through mode. It also holds a small byte-lane memory array. On each rising clock edge it samples two address strobes, an advance enable, three chip selects and a set of write enables. From these it decides whether the cycle is a deselect, the start of a read or write burst, a continued burst step or a suspended step. It then performs an array read, or a write masked by byte lane.

Read data is taken from the address captured on the current edge and appears during that same cycle, with no extra output register. The shared data pins are modelled as three parts: an input word, an output word and a drive flag. An output-enable input and a sleep input act without the clock. A two-bit burst sequencer produces the low address bits and can step in either linear or interleaved order.

Top module: `fsram_flow`

## Requirements
- R1: A cycle carries write intent when `allWriteN` is 0 (all lanes are written), or when `laneWriteN` is 0 and at least one bit of `laneMaskN` is 0. In every other case the cycle is a read.
- R2: When `allWriteN` is 1 and `laneWriteN` is 0, only the lanes whose `laneMaskN` bit is 0 are written. Lane k is data bits [8k+7:8k]. The other lanes keep their stored contents.
- R3: While `chipSelN` is 1, `procStrobeN` is ignored. If a burst is active, the cycle then behaves as a continue or suspend step.
- R4: `chipSel2` (active high) and `chipSel3N` (active low) are sampled only on a cycle where an address strobe is honoured. A strobe with either of them false deselects the device. On continue cycles they have no effect.
- R5: `ctrlStrobeN` low while the chip selects are false gives a deselect cycle. The next cycle does not drive the bus, no write takes place, and later continue cycles perform no access until a new burst starts.
- R6: A burst started by `procStrobeN` is always a read. A burst started by `ctrlStrobeN` is a write when write intent is true and a read otherwise. A begin cycle uses `addrIn` directly.
- R7: With both strobes high during an active burst, `advanceN` at 0 steps to the next burst address and `advanceN` at 1 repeats the current address. Either step reads or writes according to that cycle's write intent.
- R8: Only the two low address bits follow the burst order. With `burstLinear` at 1, step n uses (start+n) mod 4. With `burstLinear` at 0, step n uses start XOR n. After four steps the address returns to the start.
- R9: For a read, the data at the address captured on an edge is on `dataOut` with `dataDrive` high before the next edge.
- R10: During a cycle that follows a write, `dataDrive` is low. After a read, all lanes are driven whatever the byte enables are.
- R11: `outEnN` at 1 clears `dataDrive` at once, with no clock edge needed. A read made while it is 1 (a dummy read) still advances the burst counter.
- R12: While `sleep` is 1, `dataDrive` is low at once and no read, write or counter change happens. Stored data and the burst position are kept.
- R13: Reset, active low, clears any active burst and holds `dataDrive` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| chipSelN | input | 1 | First chip select, active low; masks the processor strobe |
| chipSel2 | input | 1 | Second chip select, active high |
| chipSel3N | input | 1 | Third chip select, active low |
| allWriteN | input | 1 | Write all lanes, active low |
| laneWriteN | input | 1 | Enables per-lane writes, active low |
| laneMaskN | input | LANES | Per-lane write selects, active low |
| burstLinear | input | 1 | 1 = linear burst order, 0 = interleaved |
| outEnN | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep, active high, asynchronous |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | LANES*LANE_W | Write data from the bus |
| dataOut | output | LANES*LANE_W | Read data toward the bus |
| dataDrive | output | 1 | High when the block drives the bus |

## Verification
The stimulus table runs a controller-started write burst followed by a processor-started read burst over the same four words. This separates a counter that steps from one that repeats (suspend) and shows where the counter wraps. Byte-masked writes into a word that was first filled with a known pattern show whether each lane was written or kept. A masked write with no lane selected must turn into a read. Three strobe cases are tried: a strobe masked by the first chip select, a strobe with the second or third select false, and a deselect issued in the middle of a burst. These tell apart three behaviours: an ignored strobe, a deselect that ends the burst, and chip selects that are not sampled on continue cycles. Directed tests then cover interleaved order, dummy reads made with the output enable off, the output enable and sleep inputs acting without a clock edge, and sleep keeping both the data and the burst position.

// File: rtl/fsram_pkg.sv
package fsram_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_DESEL,
    CYC_RD_BEGIN,
    CYC_WR_BEGIN,
    CYC_CONT
  } cycKind_t;

  typedef struct packed {
    logic doAccess;
    logic doWrite;
    logic loadAddr;
    logic stepCnt;
  } ctlStrobes_t;

endpackage

// File: rtl/fsram_burst_seq.sv
module fsram_burst_seq #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] startLow,
  input  logic [CNT_W-1:0] stepIdx,
  input  logic             linearOrder,
  output logic [CNT_W-1:0] seqLow
);
  always_comb begin
    if (linearOrder) seqLow = startLow + stepIdx;
    else             seqLow = startLow ^ stepIdx;
  end
endmodule

// File: rtl/fsram_ctrl.sv
module fsram_ctrl
  import fsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             chipSelN,
  input  logic             chipSel2,
  input  logic             chipSel3N,
  input  logic             allWriteN,
  input  logic             laneWriteN,
  input  logic [LANES-1:0] laneMaskN,
  input  logic             sleep,
  output ctlStrobes_t      stb,
  output logic [LANES-1:0] laneWe
);
  logic       writeIntent;
  logic [LANES-1:0] laneSel;
  logic       selTrue;
  logic       procBegin;
  logic       burstActive;
  cycKind_t   cyc;

  always_comb begin
    writeIntent = !allWriteN || (!laneWriteN && (laneMaskN != '1));
    if (!allWriteN)       laneSel = '1;
    else if (!laneWriteN) laneSel = ~laneMaskN;
    else                  laneSel = '0;
    selTrue   = !chipSelN && chipSel2 && !chipSel3N;
    procBegin = !procStrobeN && !chipSelN;

    if (sleep)              cyc = CYC_NONE;
    else if (procBegin)     cyc = selTrue ? CYC_RD_BEGIN : CYC_DESEL;
    else if (!ctrlStrobeN)  cyc = !selTrue ? CYC_DESEL
                                : (writeIntent ? CYC_WR_BEGIN : CYC_RD_BEGIN);
    else if (burstActive)   cyc = CYC_CONT;
    else                    cyc = CYC_NONE;
  end

  always_comb begin
    stb = '0;
    unique case (cyc)
      CYC_RD_BEGIN: begin stb.doAccess = 1'b1; stb.loadAddr = 1'b1; end
      CYC_WR_BEGIN: begin stb.doAccess = 1'b1; stb.loadAddr = 1'b1; stb.doWrite = 1'b1; end
      CYC_CONT: begin
        stb.doAccess = 1'b1;
        stb.doWrite  = writeIntent;
        stb.stepCnt  = !advanceN;
      end
      default: stb = '0;
    endcase
    laneWe = stb.doWrite ? laneSel : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstActive <= 1'b0;
    else if (cyc == CYC_RD_BEGIN || cyc == CYC_WR_BEGIN) burstActive <= 1'b1;
    else if (cyc == CYC_DESEL) burstActive <= 1'b0;
  end
endmodule

// File: rtl/fsram_datapath.sv
module fsram_datapath
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             stb,
  input  logic [LANES-1:0]        laneWe,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic                    burstLinear,
  input  logic                    outEnN,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] effAddr;
  logic [CNT_W-1:0]  burstCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  seqLow;
  logic              readValid;

  assign nextCnt = stb.stepCnt ? burstCnt + 1'b1 : burstCnt;

  fsram_burst_seq #(.CNT_W(CNT_W)) u_seq (
    .startLow   (baseAddr[CNT_W-1:0]),
    .stepIdx    (nextCnt),
    .linearOrder(burstLinear),
    .seqLow     (seqLow)
  );

  assign effAddr = stb.loadAddr ? addrIn : {baseAddr[ADDR_W-1:CNT_W], seqLow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      burstCnt  <= '0;
      rdAddr    <= '0;
      readValid <= 1'b0;
    end else if (stb.doAccess) begin
      if (stb.loadAddr) begin
        baseAddr <= addrIn;
        burstCnt <= '0;
      end else begin
        burstCnt <= nextCnt;
      end
      rdAddr    <= effAddr;
      readValid <= !stb.doWrite;
    end else begin
      readValid <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (laneWe[g]) laneMem[effAddr] <= dataIn[g*LANE_W +: LANE_W];
    end
    assign dataOut[g*LANE_W +: LANE_W] = laneMem[rdAddr];
  end

  assign dataDrive = readValid && !outEnN && !sleep;
endmodule

// File: rtl/fsram_flow.sv
module fsram_flow
  import fsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advanceN,
  input  logic                    chipSelN,
  input  logic                    chipSel2,
  input  logic                    chipSel3N,
  input  logic                    allWriteN,
  input  logic                    laneWriteN,
  input  logic [LANES-1:0]        laneMaskN,
  input  logic                    burstLinear,
  input  logic                    outEnN,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataDrive
);
  localparam int CNT_W = 2;

  ctlStrobes_t      stb;
  logic [LANES-1:0] laneWe;

  fsram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advanceN(advanceN),
    .chipSelN(chipSelN), .chipSel2(chipSel2), .chipSel3N(chipSel3N),
    .allWriteN(allWriteN), .laneWriteN(laneWriteN), .laneMaskN(laneMaskN),
    .sleep(sleep), .stb(stb), .laneWe(laneWe)
  );

  fsram_datapath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .laneWe(laneWe),
    .addrIn(addrIn), .dataIn(dataIn), .burstLinear(burstLinear),
    .outEnN(outEnN), .sleep(sleep), .dataOut(dataOut), .dataDrive(dataDrive)
  );
endmodule

// File: rtl/fsram_flow_chk.sv
module fsram_flow_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             procStrobeN,
  input logic             ctrlStrobeN,
  input logic             chipSelN,
  input logic             chipSel2,
  input logic             chipSel3N,
  input logic             allWriteN,
  input logic             laneWriteN,
  input logic [LANES-1:0] laneMaskN,
  input logic             outEnN,
  input logic             sleep,
  input logic             dataDrive
);
  logic selOk, procTaken, intent;
  assign selOk     = !chipSelN && chipSel2 && !chipSel3N;
  assign procTaken = !procStrobeN && !chipSelN;
  assign intent    = !allWriteN || (!laneWriteN && (laneMaskN != '1));

  p_oe_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !dataDrive);

  p_sleep_off_r12: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataDrive);

  p_write_hiz_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !procTaken && selOk && intent && !sleep) |=> !dataDrive);

  p_desel_hiz_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && !procTaken && !selOk && !sleep) |=> !dataDrive);

  p_proc_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (procTaken && selOk && !sleep) |=> (dataDrive || outEnN || sleep));
endmodule

bind fsram_flow fsram_flow_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/fsram_flow_tb.sv
module fsram_flow_tb;
  typedef struct packed {
    logic ps, cs, adv, ce1N, ce2, ce3N, gw, bw;
    logic [3:0]  lm;
    logic [5:0]  addr;
    logic [31:0] din;
    logic        drv;
    logic [31:0] dat;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  // fields: ps cs adv ce1N ce2 ce3N gw bw lm addr din expDrive expData req
  localparam vec_t VEC [NVEC] = '{
    '{1,0,1,0,1,0,0,1,4'hF,6'd8, 32'h11111111,0,32'h0,8'd6},        // R6 ctrl write begin
    '{1,1,0,0,1,0,0,1,4'hF,6'd0, 32'h22222222,0,32'h0,8'd7},        // R7 write continue
    '{1,1,0,0,1,0,0,1,4'hF,6'd0, 32'h33333333,0,32'h0,8'd7},
    '{1,1,0,0,1,0,0,1,4'hF,6'd0, 32'h44444444,0,32'h0,8'd10},       // R10
    '{0,1,1,0,1,0,1,1,4'hF,6'd8, 32'h0,1,32'h11111111,8'd6},        // R6 proc read
    '{1,1,0,0,1,0,1,1,4'hF,6'd0, 32'h0,1,32'h22222222,8'd7},
    '{1,1,1,0,1,0,1,1,4'hF,6'd0, 32'h0,1,32'h22222222,8'd7},        // R7 suspend
    '{1,1,0,0,1,0,1,1,4'hF,6'd0, 32'h0,1,32'h33333333,8'd7},
    '{1,1,0,0,1,0,1,1,4'hF,6'd0, 32'h0,1,32'h44444444,8'd9},        // R9
    '{1,1,0,0,1,0,1,1,4'hF,6'd0, 32'h0,1,32'h11111111,8'd8},        // R8 wrap
    '{1,0,1,0,1,0,1,0,4'b0101,6'd9,32'hAABBCCDD,0,32'h0,8'd2},      // R2 lanes 1,3
    '{1,0,1,0,1,0,1,0,4'hF,6'd9, 32'h0,1,32'hAA22CC22,8'd1},        // R1 no lane -> read
    '{0,1,1,1,1,0,1,1,4'hF,6'd8, 32'h0,1,32'hAA22CC22,8'd3},        // R3 masked strobe
    '{0,1,1,0,0,0,1,1,4'hF,6'd10,32'h0,0,32'h0,8'd4},               // R4 deselect
    '{1,1,0,0,1,0,1,1,4'hF,6'd0, 32'h0,0,32'h0,8'd5},               // R5 no burst
    '{0,1,1,0,1,0,1,1,4'hF,6'd10,32'h0,1,32'h33333333,8'd6},
    '{1,1,0,0,0,1,1,1,4'hF,6'd0, 32'h0,1,32'h44444444,8'd4},        // R4 unsampled
    '{1,0,1,0,1,1,0,1,4'hF,6'd8, 32'hFFFFFFFF,0,32'h0,8'd5},        // R5 deselect
    '{0,1,1,0,1,0,1,1,4'hF,6'd8, 32'h0,1,32'h11111111,8'd5},        // R5 no write
    '{1,0,1,0,1,0,1,1,4'hF,6'd11,32'h0,1,32'h44444444,8'd6},        // R6 ctrl read
    '{1,1,0,0,1,0,0,1,4'hF,6'd0, 32'h55555555,0,32'h0,8'd7},        // R7 wrap write to 8
    '{1,1,1,0,1,0,1,0,4'hF,6'd0, 32'h0,1,32'h55555555,8'd7}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobeN = 1, ctrlStrobeN = 1, advanceN = 1;
  logic chipSelN = 0, chipSel2 = 1, chipSel3N = 0;
  logic allWriteN = 1, laneWriteN = 1;
  logic [3:0]  laneMaskN = 4'hF;
  logic burstLinear = 1, outEnN = 0, sleep = 0;
  logic [5:0]  addrIn = '0;
  logic [31:0] dataIn = '0;
  logic [31:0] dataOut;
  logic        dataDrive;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fsram_flow u_dut (.*);

  task automatic apply(input vec_t v);
    procStrobeN = v.ps; ctrlStrobeN = v.cs; advanceN = v.adv;
    chipSelN = v.ce1N; chipSel2 = v.ce2; chipSel3N = v.ce3N;
    allWriteN = v.gw; laneWriteN = v.bw; laneMaskN = v.lm;
    addrIn = v.addr; dataIn = v.din;
  endtask

  task automatic check(input int req, input logic expDrv, input logic [31:0] expDat);
    checks++;
    if (dataDrive !== expDrv || (expDrv && dataOut !== expDat)) begin
      fails++;
      $display("FAIL R%0d: drive=%0b data=%h expected drive=%0b data=%h",
               req, dataDrive, dataOut, expDrv, expDat);
    end
  endtask

  function automatic vec_t idle(input logic adv);
    vec_t v = '{1,1,1,0,1,0,1,1,4'hF,6'd0,32'h0,0,32'h0,8'd0};
    v.adv = adv;
    return v;
  endfunction

  function automatic vec_t procRd(input logic [5:0] a);
    vec_t v = idle(1'b1);
    v.ps = 1'b0; v.addr = a;
    return v;
  endfunction

  task automatic cyc(input vec_t v);
    @(negedge clk); apply(v); @(posedge clk); #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; check(13, 1'b0, 32'h0);                 // R13 reset state
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i]);
      check(int'(VEC[i].req), VEC[i].drv, VEC[i].dat);
    end

    // R8 interleaved order from start 01: 9, 8, 11, 10, then 9
    burstLinear = 1'b0;
    cyc(procRd(6'd9));  check(8, 1, 32'hAA22CC22);
    cyc(idle(1'b0));    check(8, 1, 32'h55555555);
    cyc(idle(1'b0));    check(8, 1, 32'h44444444);
    cyc(idle(1'b0));    check(8, 1, 32'h33333333);
    cyc(idle(1'b0));    check(8, 1, 32'hAA22CC22);
    @(negedge clk); burstLinear = 1'b1;

    // R11 dummy reads advance the counter
    outEnN = 1'b1;
    cyc(procRd(6'd8));  check(11, 0, 32'h0);
    cyc(idle(1'b0));    check(11, 0, 32'h0);
    @(negedge clk); outEnN = 1'b0; apply(idle(1'b1)); @(posedge clk); #2;
    check(11, 1, 32'hAA22CC22);
    @(negedge clk); outEnN = 1'b1; #1; check(11, 0, 32'h0);  // R11 no edge needed
    outEnN = 1'b0; #1; check(11, 1, 32'hAA22CC22);

    // R12 sleep: drivers off at once, writes and steps blocked
    @(negedge clk); sleep = 1'b1; #1; check(12, 0, 32'h0);
    begin
      vec_t w = idle(1'b1);
      w.cs = 1'b0; w.gw = 1'b0; w.addr = 6'd9; w.din = 32'h0;
      apply(w); @(posedge clk); #2; check(12, 0, 32'h0);
    end
    cyc(idle(1'b0)); check(12, 0, 32'h0);
    @(negedge clk); sleep = 1'b0; apply(idle(1'b1)); @(posedge clk); #2;
    check(12, 1, 32'hAA22CC22);

    // R13 reset ends the burst
    @(negedge clk); rstN = 1'b0; #1; check(13, 0, 32'h0);
    @(negedge clk); rstN = 1'b1;
    cyc(idle(1'b0)); check(13, 0, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule